// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block recovers 8-bit characters from an asynchronous serial line. It runs on a clock at eight times the bit rate. When the line falls, a bit timer restarts from zero and produces one sampling tick per bit period, placed near the centre of each bit. After a low start bit is confirmed, the block samples the data bits least significant first. If parity is enabled it then samples a parity bit, and finally it samples the stop bit. The stop-bit sample moves the assembled byte into a holding register and sets a "byte ready" flag.

Three sticky error flags record framing faults (a low stop bit), overrun (a new byte arrives while the previous one is still unread) and parity mismatch. Parity can be off, even or odd. The input level can be inverted by a configuration bit. An interrupt output follows the ready flag when enabled. A data clock output is held high except while data bits are being received. During a byte it gives one rising edge right after each data bit is captured, so an external checker such as a CRC engine can clock in the bit stream.

The consumer pulses `buf_rd` after taking `rx_data`, which clears the ready flag. It pulses `stat_rd` after inspecting the error flags, which clears all three.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `rx_full`, `err_frame`, `err_overrun`, `err_parity` and `irq` are 0, `rx_data` is 0 and `data_clk` is 1.
- R2: A frame is a low start bit, eight data bits sent least significant first, an optional parity bit and a stop bit. Each bit lasts eight clocks. The stop-bit sample loads the byte into `rx_data` and sets `rx_full`. `rx_data` does not change at any other time.
- R3: A low pulse on the line that is gone by the middle of the start bit (two clocks or less) is rejected. Nothing is loaded and no data clock edges appear.
- R4: With `cfg_parity_en`=1, one parity bit follows the data. `cfg_parity_odd`=0 expects an even number of ones across data and parity, and 1 expects an odd number. A mismatch sets `err_parity`. With `cfg_parity_en`=0 no parity bit is expected and `err_parity` is never set.
- R5: A low stop bit sets `err_frame`, and the byte is still loaded into `rx_data` with `rx_full` set.
- R6: If `rx_full` is still 1 when a new stop bit is sampled, `err_overrun` is set and `rx_data` is overwritten with the new byte.
- R7: A `buf_rd` pulse clears `rx_full` and leaves the error flags untouched. A `stat_rd` pulse clears all three error flags. A set event in the same cycle as a clear wins. Error flags otherwise hold until `stat_rd`.
- R8: `irq` is 1 exactly when `cfg_irq_en` is 1 and `rx_full` is 1.
- R9: With `cfg_invert`=1 the pin is read inverted, so the idle level is low and all bit values are complemented before decoding.
- R10: `data_clk` is 1 whenever data bits are not being received. Each received frame produces exactly eight rising edges of `data_clk`, each one clock after a data bit is captured.
- R11: After a low stop bit, the receiver waits for the line to return high before it can accept a new start bit. A line held low past the stop bit therefore yields no extra byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at eight times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_in | input | 1 | Serial line from the pin |
| cfg_invert | input | 1 | 1 = read the pin inverted |
| cfg_parity_en | input | 1 | 1 = a parity bit follows the data |
| cfg_parity_odd | input | 1 | 0 = even parity, 1 = odd parity |
| cfg_irq_en | input | 1 | Enables `irq` from the ready flag |
| buf_rd | input | 1 | One-cycle pulse: the buffer has been read |
| stat_rd | input | 1 | One-cycle pulse: the error flags have been read |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Byte ready, not yet read |
| err_frame | output | 1 | Sticky: a stop bit was sampled low |
| err_overrun | output | 1 | Sticky: a byte arrived while the buffer was full |
| err_parity | output | 1 | Sticky: parity mismatch |
| irq | output | 1 | Interrupt request |
| data_clk | output | 1 | Bit clock for external checking; high when idle |

## Verification
The bench sends a short glitch on an idle line. A receiver that skipped the mid-start confirmation would lock onto it and produce a byte of all ones with spurious data clock edges. It also holds the line low well past a bad stop bit. A receiver without the wait-for-high step would start a phantom frame there and raise `rx_full` again after the buffer was read. Back-to-back bytes with no read in between catch an overrun flag tied to the wrong condition, or a buffer that keeps the old byte. Random frames mix even, odd and absent parity, deliberately wrong parity bits, bad stop bits, inverted lines and interleaved clear pulses. Together they expose reversed bit order, a parity sense that is flipped, and error flags that clear on the wrong pulse.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4,
    ST_HOLD   = 3'd5
  } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic invert,
  output logic line
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              polar;

  // Polarity is fixed before the first flop so a config change walks
  // through the synchroniser like any other line transition.
  assign polar = raw_in ^ invert;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = polar;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], polar};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign line = sync_q[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int OVS = 8,
  parameter int MID = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic in_data,
  output logic mid_tick,
  output logic data_clk
);

  localparam int CW        = $clog2(OVS);
  localparam int HALF      = OVS / 2;
  localparam int LOW_START = (MID + 1 + OVS - HALF) % OVS;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] phase;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign mid_tick = run && (cnt_q == CW'(MID));

  // Low for the half period that ends at the sampling edge, so the
  // rising edge lands one clock after each data capture.
  assign phase    = cnt_q - CW'(LOW_START);
  assign data_clk = in_data ? (phase >= CW'(HALF)) : 1'b1;

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line,
  input  logic                 mid_tick,
  input  logic                 par_en,
  input  logic                 par_odd,
  output rx_state_e            state,
  output logic                 start_seen,
  output logic                 done,
  output logic                 stop_ok,
  output logic                 par_bad,
  output logic [DATA_BITS-1:0] done_data
);

  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  rx_state_e            state_q, state_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic [DATA_BITS-1:0] shreg_q, shreg_d;
  logic                 pbad_q, pbad_d;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    shreg_d    = shreg_q;
    pbad_d     = pbad_q;
    start_seen = 1'b0;
    done       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!line) begin
          state_d    = ST_START;
          start_seen = 1'b1;
        end
      end
      ST_START: begin
        if (mid_tick) begin
          if (line) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_DATA;
            idx_d   = '0;
            pbad_d  = 1'b0;
          end
        end
      end
      ST_DATA: begin
        if (mid_tick) begin
          shreg_d = {line, shreg_q[DATA_BITS-1:1]};
          idx_d   = idx_q + 1'b1;
          if (idx_q == IW'(DATA_BITS - 1)) begin
            state_d = par_en ? ST_PARITY : ST_STOP;
          end
        end
      end
      ST_PARITY: begin
        if (mid_tick) begin
          pbad_d  = ((^shreg_q) ^ line) != par_odd;
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (mid_tick) begin
          done    = 1'b1;
          state_d = line ? ST_IDLE : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (line) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
      pbad_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shreg_q <= shreg_d;
      pbad_q  <= pbad_d;
    end
  end

  assign state     = state_q;
  assign stop_ok   = line;
  assign par_bad   = pbad_q;
  assign done_data = shreg_q;

endmodule

// File: rtl/rx_result_regs.sv
module rx_result_regs #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] done_data,
  input  logic                 stop_ok,
  input  logic                 par_bad,
  input  logic                 buf_rd,
  input  logic                 stat_rd,
  input  logic                 irq_en,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_full,
  output logic                 err_frame,
  output logic                 err_overrun,
  output logic                 err_parity,
  output logic                 irq
);

  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 full_q, full_d;
  logic                 fe_q, fe_d;
  logic                 oe_q, oe_d;
  logic                 pe_q, pe_d;

  always_comb begin
    data_d = data_q;
    full_d = full_q;
    fe_d   = fe_q;
    oe_d   = oe_q;
    pe_d   = pe_q;
    if (buf_rd) begin
      full_d = 1'b0;
    end
    if (stat_rd) begin
      fe_d = 1'b0;
      oe_d = 1'b0;
      pe_d = 1'b0;
    end
    if (done) begin
      data_d = done_data;
      full_d = 1'b1;
      if (!stop_ok) begin
        fe_d = 1'b1;
      end
      if (full_q && !buf_rd) begin
        oe_d = 1'b1;
      end
      if (par_bad) begin
        pe_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      fe_q   <= 1'b0;
      oe_q   <= 1'b0;
      pe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      fe_q   <= fe_d;
      oe_q   <= oe_d;
      pe_q   <= pe_d;
    end
  end

  assign rx_data     = data_q;
  assign rx_full     = full_q;
  assign err_frame   = fe_q;
  assign err_overrun = oe_q;
  assign err_parity  = pe_q;
  assign irq         = irq_en & full_q;

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 8,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_in,
  input  logic                 cfg_invert,
  input  logic                 cfg_parity_en,
  input  logic                 cfg_parity_odd,
  input  logic                 cfg_irq_en,
  input  logic                 buf_rd,
  input  logic                 stat_rd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_full,
  output logic                 err_frame,
  output logic                 err_overrun,
  output logic                 err_parity,
  output logic                 irq,
  output logic                 data_clk
);

  // Sampling count inside a bit, pulled earlier by the synchroniser
  // latency so the capture lands at the bit centre on the pin.
  localparam int MID_RAW   = OVERSAMPLE / 2 - SYNC_STAGES;
  localparam int MID_COUNT = (MID_RAW < 0) ? 0 : MID_RAW;

  logic                 line;
  logic                 mid_tick;
  logic                 start_seen;
  logic                 frame_done;
  logic                 stop_ok;
  logic                 par_bad;
  logic [DATA_BITS-1:0] frame_byte;
  rx_state_e            fsm_state;
  logic                 timer_run;
  logic                 in_data;

  rx_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (rx_in),
    .invert (cfg_invert),
    .line   (line)
  );

  assign timer_run = (fsm_state != ST_IDLE) && (fsm_state != ST_HOLD);
  assign in_data   = (fsm_state == ST_DATA);

  rx_bit_timer #(
    .OVS (OVERSAMPLE),
    .MID (MID_COUNT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (timer_run),
    .restart  (start_seen),
    .in_data  (in_data),
    .mid_tick (mid_tick),
    .data_clk (data_clk)
  );

  rx_frame_fsm #(
    .DATA_BITS (DATA_BITS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .line       (line),
    .mid_tick   (mid_tick),
    .par_en     (cfg_parity_en),
    .par_odd    (cfg_parity_odd),
    .state      (fsm_state),
    .start_seen (start_seen),
    .done       (frame_done),
    .stop_ok    (stop_ok),
    .par_bad    (par_bad),
    .done_data  (frame_byte)
  );

  rx_result_regs #(
    .DATA_BITS (DATA_BITS)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (frame_done),
    .done_data   (frame_byte),
    .stop_ok     (stop_ok),
    .par_bad     (par_bad),
    .buf_rd      (buf_rd),
    .stat_rd     (stat_rd),
    .irq_en      (cfg_irq_en),
    .rx_data     (rx_data),
    .rx_full     (rx_full),
    .err_frame   (err_frame),
    .err_overrun (err_overrun),
    .err_parity  (err_parity),
    .irq         (irq)
  );

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 buf_rd,
  input logic                 stat_rd,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_full,
  input logic                 err_frame,
  input logic                 err_overrun,
  input logic                 err_parity,
  input logic                 data_clk,
  input logic                 frame_done,
  input rx_state_e            fsm_state
);

  AST_FULL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_full); // R2

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(rx_data)); // R2

  AST_FRAME_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame) |-> $past(frame_done)); // R5

  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_full)); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !frame_done) |=> !rx_full); // R7

  AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity && !stat_rd) |=> err_parity); // R7

  AST_DCLK_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_clk) |-> (fsm_state == ST_DATA)); // R10

  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_HOLD) |=> (fsm_state == ST_HOLD || fsm_state == ST_IDLE)); // R11

endmodule

bind uart_rx_core uart_rx_checker #(
  .DATA_BITS (DATA_BITS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .buf_rd      (buf_rd),
  .stat_rd     (stat_rd),
  .rx_data     (rx_data),
  .rx_full     (rx_full),
  .err_frame   (err_frame),
  .err_overrun (err_overrun),
  .err_parity  (err_parity),
  .data_clk    (data_clk),
  .frame_done  (frame_done),
  .fsm_state   (fsm_state)
);

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;

  logic       clk;
  logic       rst_n;
  logic       rx_in;
  logic       cfg_invert;
  logic       cfg_parity_en;
  logic       cfg_parity_odd;
  logic       cfg_irq_en;
  logic       buf_rd;
  logic       stat_rd;
  logic [7:0] rx_data;
  logic       rx_full;
  logic       err_frame;
  logic       err_overrun;
  logic       err_parity;
  logic       irq;
  logic       data_clk;

  int checks;
  int errors;
  int rises;
  logic dclk_prev;
  bit done_flag;

  // model state
  logic [7:0] exp_data;
  bit exp_full, exp_fe, exp_oe, exp_pe;
  bit inv_cur;

  uart_rx_core dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_in          (rx_in),
    .cfg_invert     (cfg_invert),
    .cfg_parity_en  (cfg_parity_en),
    .cfg_parity_odd (cfg_parity_odd),
    .cfg_irq_en     (cfg_irq_en),
    .buf_rd         (buf_rd),
    .stat_rd        (stat_rd),
    .rx_data        (rx_data),
    .rx_full        (rx_full),
    .err_frame      (err_frame),
    .err_overrun    (err_overrun),
    .err_parity     (err_parity),
    .irq            (irq),
    .data_clk       (data_clk)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    dclk_prev <= data_clk;
    if (rst_n && data_clk && !dclk_prev) rises <= rises + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit par_bit(input logic [7:0] b, input bit odd, input bit wrong);
    return (^b) ^ odd ^ wrong;
  endfunction

  task automatic drive_bit(input bit v, input int cycles);
    rx_in = v ^ inv_cur;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit pen, input bit podd,
                            input bit wrong_par, input bit stop_v, input int low_tail,
                            output int edges);
    int base;
    @(negedge clk);
    cfg_parity_en  = pen;
    cfg_parity_odd = podd;
    base = rises;
    drive_bit(1'b0, 8);
    for (int i = 0; i < 8; i++) drive_bit(b[i], 8);
    if (pen) drive_bit(par_bit(b, podd, wrong_par), 8);
    drive_bit(stop_v, 8 + low_tail);
    drive_bit(1'b1, 6);
    edges = rises - base;
    exp_oe   = exp_oe | exp_full;
    exp_full = 1'b1;
    exp_data = b;
    if (!stop_v) exp_fe = 1'b1;
    if (pen && wrong_par) exp_pe = 1'b1;
  endtask

  task automatic do_buf_rd();
    @(negedge clk) buf_rd = 1'b1;
    @(negedge clk) buf_rd = 1'b0;
    exp_full = 1'b0;
  endtask

  task automatic do_stat_rd();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    exp_fe = 1'b0;
    exp_oe = 1'b0;
    exp_pe = 1'b0;
  endtask

  task automatic set_inv(input bit v);
    @(negedge clk);
    cfg_invert = v;
    inv_cur    = v;
    rx_in      = 1'b1 ^ v;
    repeat (16) @(negedge clk);
  endtask

  task automatic check_all(input int edges, input int exp_edges);
    check("R2 data", rx_data, exp_data);
    check("R2 full", rx_full, exp_full);
    check("R5 framing", err_frame, exp_fe);
    check("R6 overrun", err_overrun, exp_oe);
    check("R4 parity", err_parity, exp_pe);
    check("R8 irq", irq, cfg_irq_en & exp_full);
    check("R10 dclk edges", edges, exp_edges);
    check("R10 dclk idle", data_clk, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e;
    logic [7:0] b;
    bit pen, podd, wp, sv;
    checks = 0; errors = 0; rises = 0; dclk_prev = 1'b1; done_flag = 0;
    exp_data = '0; exp_full = 0; exp_fe = 0; exp_oe = 0; exp_pe = 0; inv_cur = 0;
    rst_n = 1'b0; rx_in = 1'b1; cfg_invert = 1'b0; cfg_parity_en = 1'b0;
    cfg_parity_odd = 1'b0; cfg_irq_en = 1'b1; buf_rd = 1'b0; stat_rd = 1'b0;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    // R1 reset values
    check("R1 data", rx_data, 8'h00);
    check("R1 full", rx_full, 1'b0);
    check("R1 errors", {err_frame, err_overrun, err_parity}, 3'b000);
    check("R1 irq", irq, 1'b0);
    check("R1 dclk", data_clk, 1'b1);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R2 LSB-first byte, no parity
    send_frame(8'hA5, 0, 0, 0, 1, 0, e);
    check_all(e, 8);
    // R6 second byte without read overwrites and flags overrun
    send_frame(8'h3C, 0, 0, 0, 1, 0, e);
    check_all(e, 8);
    check("R6 overwritten", rx_data, 8'h3C);
    // R7 buf_rd clears full, keeps errors
    do_buf_rd();
    @(negedge clk);
    check("R7 full cleared", rx_full, 1'b0);
    check("R7 overrun kept", err_overrun, 1'b1);
    check("R8 irq low", irq, 1'b0);
    do_stat_rd();
    @(negedge clk);
    check("R7 errors cleared", {err_frame, err_overrun, err_parity}, 3'b000);

    // R4 parity cases
    send_frame(8'h81, 1, 0, 0, 1, 0, e);
    check_all(e, 8);
    do_buf_rd();
    send_frame(8'h7F, 1, 0, 1, 1, 0, e);
    check_all(e, 8);
    do_buf_rd(); do_stat_rd();
    send_frame(8'h12, 1, 1, 0, 1, 0, e);
    check_all(e, 8);
    do_buf_rd();
    send_frame(8'h12, 1, 1, 1, 1, 0, e);
    check_all(e, 8);
    do_buf_rd(); do_stat_rd();

    // R5 and R11: bad stop with line held low afterwards
    send_frame(8'hC3, 0, 0, 0, 0, 40, e);
    check_all(e, 8);
    check("R5 byte loaded", rx_data, 8'hC3);
    do_buf_rd();
    repeat (100) @(negedge clk);
    check("R11 no phantom byte", rx_full, 1'b0);
    do_stat_rd();

    // R3 glitch rejected
    begin
      int base;
      base = rises;
      @(negedge clk) rx_in = 1'b0;
      repeat (2) @(negedge clk);
      rx_in = 1'b1;
      repeat (100) @(negedge clk);
      check("R3 no load", rx_full, 1'b0);
      check("R3 data kept", rx_data, 8'hC3);
      check("R3 no dclk", rises - base, 0);
    end

    // R9 inverted line
    set_inv(1'b1);
    send_frame(8'h4B, 1, 0, 0, 1, 0, e);
    check_all(e, 8);
    check("R9 inverted data", rx_data, 8'h4B);
    do_buf_rd();
    set_inv(1'b0);

    // random frames
    for (int n = 0; n < 40; n++) begin
      b    = 8'($urandom);
      pen  = bit'($urandom % 2);
      podd = bit'($urandom % 2);
      wp   = ($urandom % 4) == 0;
      sv   = ($urandom % 5) != 0;
      cfg_irq_en = bit'($urandom % 2);
      if (($urandom % 4) == 0) set_inv(~inv_cur);
      if (($urandom % 2) == 0) do_buf_rd();
      if (($urandom % 3) == 0) do_stat_rd();
      send_frame(b, pen, podd, wp, sv, 0, e);
      check_all(e, 8);
    end

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule